// File: doc/BRIEF.md
# Hierarchical State-Enable Register Bank

This block holds three tiers of state-enable control registers (machine, hypervisor and supervisor), each tier holding up to four 64-bit registers. A core's CSR unit hands it one access per cycle: a 12-bit CSR address, a write flag, write data, the current privilege mode and whether virtualization is active. The block decides whether the access is legal and returns the read value or an exception code one cycle later. Legal writes are committed on the same clock edge.

The tiers form a chain of gates. The top bit of machine register N opens hypervisor register N and supervisor register N. The top bit of hypervisor register N also opens supervisor register N, but only while a virtualized guest is running. These gates affect three things. They decide whether an access is allowed. They decide which bits a write may change. They decide which bits a read shows. Machine and hypervisor registers can also be reached one upper 32-bit half at a time, for 32-bit software.

Top module: `lvl_gate_csr`

## Requirements
- R1: After reset every register is zero. A read of machine register 0 returns 0, and any hypervisor or supervisor access is rejected.
- R2: While `feat_en` is low, every access returns exception code 1 (illegal) and changes no register.
- R3: Machine register N decodes at 0x30C+N and its upper half at 0x31C+N. Hypervisor register N decodes at 0x60C+N and its upper half at 0x61C+N. Supervisor register N decodes at 0x10C+N. Every other address, and every N of NUM_REGS or more, is illegal.
- R4: Privilege encoding is 3 = machine, 1 = supervisor, 0 or 2 = user. Machine registers are legal only in machine mode.
- R5: An access to hypervisor register N is illegal when bit 63 of machine register N is clear. Otherwise it is legal only in machine mode, or in supervisor mode with virtualization inactive.
- R6: For supervisor register N the checks run in this order. First, it is illegal if bit 63 of machine register N is clear. Next, it returns code 2 (virtual-instruction fault) if virtualization is active and bit 63 of hypervisor register N is clear. Last, it is illegal unless the privilege is supervisor or machine.
- R7: Virtualization counts as active only when `virt_on` is high and the privilege is not machine.
- R8: A legal write sets reg = (reg & ~k) | (data & k). For machine registers k = WR_MASK. For hypervisor register N, k = WR_MASK & machine register N. For supervisor register N, k also includes hypervisor register N when virtualization is active. The default WR_MASK allows only bit 63 to be written.
- R9: A legal read of hypervisor register N returns its value ANDed with machine register N. A legal read of supervisor register N returns its value ANDed with machine register N, and also with hypervisor register N when virtualization is active.
- R10: An upper-half write places data[31:0] into bits 63:32, keeps bits 31:0, and then applies the R8 mask. An upper-half read returns bits 63:32 of the R9 view in rdata[31:0], with rdata[63:32] zero.
- R11: A rejected access changes no register and returns rdata zero. Exception codes are 0 = none, 1 = illegal, 2 = virtual-instruction fault.
- R12: The response (`rsp_valid`, `rsp_exc`, `rsp_rdata`) appears exactly one cycle after the request. Its read data is the value before any write carried by the same access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Feature enable; low rejects every access |
| priv | input | 2 | Current privilege (3 machine, 1 supervisor, else user) |
| virt_on | input | 1 | Virtualized guest running |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | Request is a write |
| req_addr | input | 12 | CSR address |
| req_wdata | input | DATA_W | Write data (low half used for upper-half writes) |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_exc | output | 2 | Exception code of the answered access |
| rsp_rdata | output | DATA_W | Gated read value before the write |

## Verification
Each request drives a single response one clock later. The register update from a legal write is visible to the next request, also one clock later. The bench applies stimulus just after a falling edge. At the next falling edge it compares `rsp_valid`, `rsp_exc` and `rsp_rdata` against a behavioural model that was stepped when the request was applied. The model's arrays therefore advance in the same cycle as the design's registers. Every idle cycle is also checked, to confirm that no response appears without a request.

// File: rtl/lvl_gate_pkg.sv
package lvl_gate_pkg;

   // Register tier addressed by a request; values double as generate indices
   typedef enum logic [1:0] {
      LVL_M    = 2'd0,
      LVL_H    = 2'd1,
      LVL_S    = 2'd2,
      LVL_NONE = 2'd3
   } lvl_e;

   typedef enum logic [1:0] {
      EXC_NONE    = 2'd0,
      EXC_ILLEGAL = 2'd1,
      EXC_VIRT    = 2'd2
   } exc_e;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   localparam int SLOT_W = 2;   // at most four registers per tier

   typedef struct packed {
      logic              hit;
      lvl_e              lvl;
      logic              upper;
      logic [SLOT_W-1:0] idx;
   } dec_t;

endpackage

// File: rtl/lvl_gate_decode.sv
module lvl_gate_decode
   import lvl_gate_pkg::*;
#(
   parameter int NUM_REGS = 4,
   parameter bit HALF_EN  = 1'b1
) (
   input  logic [11:0] addr,
   output dec_t        dec
);

   localparam logic [7:0] PAGE_M    = 8'h30;
   localparam logic [7:0] PAGE_M_HI = 8'h31;
   localparam logic [7:0] PAGE_H    = 8'h60;
   localparam logic [7:0] PAGE_H_HI = 8'h61;
   localparam logic [7:0] PAGE_S    = 8'h10;

   logic half_ok;
   logic slot_ok;

   generate
      if (HALF_EN) begin : g_half
         assign half_ok = 1'b1;
      end else begin : g_nohalf
         assign half_ok = 1'b0;
      end
   endgenerate

   assign slot_ok = (addr[3:2] == 2'b11) && (int'(addr[1:0]) < NUM_REGS);

   always_comb begin
      dec       = '0;
      dec.lvl   = LVL_NONE;
      dec.idx   = addr[1:0];
      if (slot_ok) begin
         unique case (addr[11:4])
            PAGE_M: begin
               dec.hit = 1'b1;
               dec.lvl = LVL_M;
            end
            PAGE_M_HI: begin
               dec.hit   = half_ok;
               dec.lvl   = half_ok ? LVL_M : LVL_NONE;
               dec.upper = half_ok;
            end
            PAGE_H: begin
               dec.hit = 1'b1;
               dec.lvl = LVL_H;
            end
            PAGE_H_HI: begin
               dec.hit   = half_ok;
               dec.lvl   = half_ok ? LVL_H : LVL_NONE;
               dec.upper = half_ok;
            end
            PAGE_S: begin
               dec.hit = 1'b1;
               dec.lvl = LVL_S;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/lvl_gate_perm.sv
module lvl_gate_perm
   import lvl_gate_pkg::*;
#(
   parameter int NUM_REGS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                feat_en,
   input  logic [1:0]          priv,
   input  logic                virt_on,
   input  dec_t                dec,
   input  logic [NUM_REGS-1:0] m_open,
   input  logic [NUM_REGS-1:0] h_open,
   output logic                virt_act,
   output exc_e                exc
);

   logic m_bit;
   logic h_bit;
   logic hs_ok;
   logic s_ok;

   always_comb begin
      m_bit = 1'b0;
      h_bit = 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (int'(dec.idx) == i) begin
            m_bit = m_open[i];
            h_bit = h_open[i];
         end
      end
   end

   assign virt_act = virt_on && (priv != PRIV_M);
   assign hs_ok    = (priv == PRIV_M) || ((priv == PRIV_S) && !virt_act);
   assign s_ok     = (priv == PRIV_M) || (priv == PRIV_S);

   always_comb begin
      exc = EXC_NONE;
      if (!feat_en || !dec.hit) begin
         exc = EXC_ILLEGAL;
      end else begin
         unique case (dec.lvl)
            LVL_M: if (priv != PRIV_M) exc = EXC_ILLEGAL;
            LVL_H: begin
               if (!m_bit)      exc = EXC_ILLEGAL;
               else if (!hs_ok) exc = EXC_ILLEGAL;
            end
            LVL_S: begin
               if (!m_bit)                 exc = EXC_ILLEGAL;
               else if (virt_act && !h_bit) exc = EXC_VIRT;
               else if (!s_ok)             exc = EXC_ILLEGAL;
            end
            default: exc = EXC_ILLEGAL;
         endcase
      end
   end

   // R6
   virt_only_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc == EXC_VIRT) |-> (dec.lvl == LVL_S) && virt_on && (priv != PRIV_M));

   // R7
   mach_never_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (priv == PRIV_M) |-> (exc != EXC_VIRT));

endmodule

// File: rtl/lvl_gate_regs.sv
module lvl_gate_regs #(
   parameter int          NUM_REGS = 4,
   parameter int          DATA_W   = 64,
   parameter logic [63:0] WR_MASK  = 64'h8000_0000_0000_0000
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [1:0]                     idx,
   input  logic [DATA_W-1:0]              mask,
   input  logic [DATA_W-1:0]              wdata,
   output logic [NUM_REGS-1:0][DATA_W-1:0] q
);

   localparam logic [DATA_W-1:0] KEEP_MASK = WR_MASK[DATA_W-1:0];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q[i] <= '0;
            end else if (we && (int'(idx) == i)) begin
               q[i] <= (q[i] & ~mask) | (wdata & mask);
            end
         end

         // R8
         nonwritable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] & ~KEEP_MASK) == '0);
      end
   endgenerate

endmodule

// File: rtl/lvl_gate_csr.sv
module lvl_gate_csr
   import lvl_gate_pkg::*;
#(
   parameter int          NUM_REGS = 4,
   parameter int          DATA_W   = 64,
   parameter logic [63:0] WR_MASK  = 64'h8000_0000_0000_0000,
   parameter bit          HALF_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              feat_en,
   input  logic [1:0]        priv,
   input  logic              virt_on,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [11:0]       req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [1:0]        rsp_exc,
   output logic [DATA_W-1:0] rsp_rdata
);

   localparam int NUM_LVL = 3;
   localparam int HALF_W  = DATA_W / 2;
   localparam int EN_BIT  = DATA_W - 1;
   localparam logic [DATA_W-1:0] BASE_MASK = WR_MASK[DATA_W-1:0];

   // Elaboration-time parameter checks
   generate
      if (NUM_REGS < 1 || NUM_REGS > 4) begin : g_bad_regs
         $error("NUM_REGS must lie in 1..4");
      end
      if (DATA_W != 64) begin : g_bad_width
         $error("DATA_W must be 64 for the upper-half alias layout");
      end
      if (WR_MASK[63] != 1'b1) begin : g_bad_mask
         $error("WR_MASK must leave the enable bit writable");
      end
   endgenerate

   dec_t                                dec;
   exc_e                                exc;
   logic                                virt_act;
   logic [NUM_REGS-1:0][DATA_W-1:0]     q_lv [NUM_LVL];
   logic [NUM_LVL-1:0]                  we_lv;
   logic [NUM_REGS-1:0]                 m_open;
   logic [NUM_REGS-1:0]                 h_open;
   logic [DATA_W-1:0]                   m_sel, h_sel, raw_sel;
   logic [DATA_W-1:0]                   gate, view, wr_mask, merged, rd_val;
   logic                                commit;

   lvl_gate_decode #(
      .NUM_REGS (NUM_REGS),
      .HALF_EN  (HALF_EN)
   ) i_decode (
      .addr (req_addr),
      .dec  (dec)
   );

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_open
         assign m_open[i] = q_lv[LVL_M][i][EN_BIT];
         assign h_open[i] = q_lv[LVL_H][i][EN_BIT];
      end
   endgenerate

   lvl_gate_perm #(
      .NUM_REGS (NUM_REGS)
   ) i_perm (
      .clk      (clk),
      .rst_n    (rst_n),
      .feat_en  (feat_en),
      .priv     (priv),
      .virt_on  (virt_on),
      .dec      (dec),
      .m_open   (m_open),
      .h_open   (h_open),
      .virt_act (virt_act),
      .exc      (exc)
   );

   // Selected register of each tier
   always_comb begin
      m_sel = '0;
      h_sel = '0;
      raw_sel = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (int'(dec.idx) == i) begin
            m_sel = q_lv[LVL_M][i];
            h_sel = q_lv[LVL_H][i];
            unique case (dec.lvl)
               LVL_M:   raw_sel = q_lv[LVL_M][i];
               LVL_H:   raw_sel = q_lv[LVL_H][i];
               LVL_S:   raw_sel = q_lv[LVL_S][i];
               default: raw_sel = '0;
            endcase
         end
      end
   end

   // Gating from the tiers above
   always_comb begin
      unique case (dec.lvl)
         LVL_H:   gate = m_sel;
         LVL_S:   gate = m_sel & (virt_act ? h_sel : '1);
         default: gate = '1;
      endcase
   end

   assign view    = raw_sel & gate;
   assign wr_mask = BASE_MASK & gate;
   assign merged  = dec.upper ? {req_wdata[HALF_W-1:0], raw_sel[HALF_W-1:0]} : req_wdata;
   assign rd_val  = dec.upper ? {{HALF_W{1'b0}}, view[DATA_W-1:HALF_W]} : view;
   assign commit  = req_valid && req_we && (exc == EXC_NONE);

   generate
      for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
         assign we_lv[l] = commit && (dec.lvl == lvl_e'(l));

         lvl_gate_regs #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .WR_MASK  (WR_MASK)
         ) i_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_lv[l]),
            .idx   (dec.idx),
            .mask  (wr_mask),
            .wdata (merged),
            .q     (q_lv[l])
         );
      end
   endgenerate

   // Response stage
   exc_e upper_exc_q;
   logic upper_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         upper_exc_q <= EXC_NONE;
         rsp_rdata   <= '0;
         upper_q     <= 1'b0;
      end else begin
         rsp_valid   <= req_valid;
         upper_exc_q <= req_valid ? exc : EXC_NONE;
         rsp_rdata   <= (req_valid && exc == EXC_NONE) ? rd_val : '0;
         upper_q     <= req_valid && dec.upper;
      end
   end

   assign rsp_exc = upper_exc_q;

   // R12
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2
   feature_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !feat_en) |=> (rsp_exc == EXC_ILLEGAL));

   // R11
   reject_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_exc != EXC_NONE) |-> (rsp_rdata == '0));

   // R11
   reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && exc != EXC_NONE) |=>
         ($stable(q_lv[LVL_M]) && $stable(q_lv[LVL_H]) && $stable(q_lv[LVL_S])));

   // R10
   upper_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && upper_q) |-> (rsp_rdata[DATA_W-1:HALF_W] == '0));

endmodule

// File: tb/test_lvl_gate_csr.sv
`timescale 1ns/1ps
module test_lvl_gate_csr;

   localparam logic [63:0] WMASK = 64'h8000_0000_F000_000F;
   localparam int          NREG  = 4;
   localparam logic [1:0]  PM = 2'd3, PS = 2'd1, PU = 2'd0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        feat_en = 1'b0;
   logic [1:0]  priv = 2'd0;
   logic        virt_on = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [11:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_exc;
   logic [63:0] rsp_rdata;

   int tests = 0;
   int fails = 0;

   logic [63:0] mm [NREG];
   logic [63:0] hh [NREG];
   logic [63:0] ss [NREG];

   always #4 clk = ~clk;   // 125 MHz

   lvl_gate_csr #(
      .NUM_REGS (NREG),
      .DATA_W   (64),
      .WR_MASK  (WMASK),
      .HALF_EN  (1'b1)
   ) i_lvl_gate_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .feat_en   (feat_en),
      .priv      (priv),
      .virt_on   (virt_on),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_exc   (rsp_exc),
      .rsp_rdata (rsp_rdata)
   );

   // Behavioural reference: returns expected code and data, updates arrays
   task automatic model(input bit we, input logic [11:0] a, input logic [63:0] d,
                        input logic [1:0] p, input bit v, input bit f,
                        output logic [1:0] ex, output logic [63:0] rd);
      int n, kind;
      bit hi, va;
      logic [63:0] old, g, nd, k;
      n = int'(a[1:0]);
      kind = 0;
      hi = 1'b0;
      if (a[3:2] == 2'b11 && n < NREG) begin
         case (a[11:4])
            8'h30: kind = 1;
            8'h31: begin kind = 1; hi = 1'b1; end
            8'h60: kind = 2;
            8'h61: begin kind = 2; hi = 1'b1; end
            8'h10: kind = 3;
            default: kind = 0;
         endcase
      end
      va = v && (p != PM);
      if (!f || kind == 0)  ex = 2'd1;
      else if (kind == 1)   ex = (p == PM) ? 2'd0 : 2'd1;
      else if (kind == 2)   ex = !mm[n][63] ? 2'd1 :
                                 ((p == PM || (p == PS && !va)) ? 2'd0 : 2'd1);
      else                  ex = !mm[n][63] ? 2'd1 :
                                 ((va && !hh[n][63]) ? 2'd2 :
                                 ((p == PM || p == PS) ? 2'd0 : 2'd1));
      rd = '0;
      if (ex == 2'd0) begin
         if (kind == 1)      begin old = mm[n]; g = '1; end
         else if (kind == 2) begin old = hh[n]; g = mm[n]; end
         else                begin old = ss[n]; g = mm[n] & (va ? hh[n] : '1); end
         rd = hi ? ((old & g) >> 32) : (old & g);
         if (we) begin
            nd = hi ? {d[31:0], old[31:0]} : d;
            k  = WMASK & g;
            nd = (old & ~k) | (nd & k);
            if (kind == 1)      mm[n] = nd;
            else if (kind == 2) hh[n] = nd;
            else                ss[n] = nd;
         end
      end
   endtask

   task automatic acc(input bit we, input logic [11:0] a, input logic [63:0] d,
                      input logic [1:0] p, input bit v, input bit f, input string tag);
      logic [1:0]  ex;
      logic [63:0] rd;
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      priv = p; virt_on = v; feat_en = f;
      model(we, a, d, p, v, f, ex, rd);
      @(negedge clk);
      tests++;
      if (rsp_valid !== 1'b1 || rsp_exc !== ex || rsp_rdata !== rd) begin
         fails++;
         $display("FAIL %s addr=%h we=%0d: got valid=%0d exc=%0d data=%h, expected valid=1 exc=%0d data=%h",
                  tag, a, we, rsp_valid, rsp_exc, rsp_rdata, ex, rd);
      end
   endtask

   task automatic idle();
      req_valid = 1'b0; req_we = 1'b0;
      @(negedge clk);
      tests++;
      if (rsp_valid !== 1'b0) begin
         fails++;
         $display("FAIL R12 idle: got valid=%0d, expected valid=0", rsp_valid);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NREG; i++) begin mm[i] = '0; hh[i] = '0; ss[i] = '0; end
      repeat (3) @(negedge clk);
      tests++;   // R1 reset outputs
      if (rsp_valid !== 1'b0 || rsp_exc !== 2'd0 || rsp_rdata !== '0) begin
         fails++;
         $display("FAIL R1 reset: got %0d/%0d/%h, expected 0/0/0", rsp_valid, rsp_exc, rsp_rdata);
      end
      rst_n = 1'b1;
      idle();

      // R1 reset contents
      acc(0, 12'h30C, '0, PM, 0, 1, "R1");
      acc(0, 12'h60C, '0, PM, 0, 1, "R1");
      acc(0, 12'h10C, '0, PS, 0, 1, "R1");
      // R2 feature disabled
      acc(1, 12'h30C, '1, PM, 0, 0, "R2");
      acc(0, 12'h30C, '0, PM, 0, 1, "R2");
      // R4 machine tier privilege
      acc(1, 12'h30C, '1, PS, 0, 1, "R4");
      acc(0, 12'h30D, '0, PU, 0, 1, "R4");
      acc(0, 12'h30C, '0, 2'd2, 0, 1, "R4");
      // R8 machine write and hypervisor write under machine gate
      acc(1, 12'h30C, '1, PM, 0, 1, "R8");
      acc(0, 12'h30C, '0, PM, 0, 1, "R8");
      acc(1, 12'h60C, '1, PM, 0, 1, "R8");
      // R12 read returns pre-write value
      acc(1, 12'h30C, 64'h8000_0000_0000_0003, PM, 0, 1, "R12");
      idle();
      // R9 readback gating
      acc(0, 12'h60C, '0, PM, 0, 1, "R9");
      acc(1, 12'h60C, '0, PM, 0, 1, "R8");
      acc(0, 12'h60C, '0, PM, 0, 1, "R9");
      acc(1, 12'h60C, '1, PM, 0, 1, "R8");
      // R3 unmapped addresses
      acc(0, 12'h30B, '0, PM, 0, 1, "R3");
      acc(0, 12'h320, '0, PM, 0, 1, "R3");
      acc(0, 12'h11C, '0, PM, 0, 1, "R3");
      acc(0, 12'h70C, '0, PM, 0, 1, "R3");
      // R5 hypervisor tier
      acc(0, 12'h60C, '0, PS, 0, 1, "R5");
      acc(0, 12'h60C, '0, PS, 1, 1, "R5");
      acc(0, 12'h60C, '0, PU, 0, 1, "R5");
      acc(0, 12'h60D, '0, PM, 0, 1, "R5");
      // R6 supervisor tier
      acc(1, 12'h10C, '1, PS, 1, 1, "R6");
      acc(0, 12'h10C, '0, PS, 1, 1, "R6");
      acc(1, 12'h60C, '0, PM, 0, 1, "R6");
      acc(0, 12'h10C, '0, PS, 1, 1, "R6");
      acc(0, 12'h10C, '0, PU, 1, 1, "R6");
      acc(0, 12'h10C, '0, PS, 0, 1, "R6");
      acc(0, 12'h10C, '0, PU, 0, 1, "R6");
      acc(0, 12'h10D, '0, PS, 1, 1, "R6");
      // R11 rejected write leaves state
      acc(1, 12'h10C, '0, PS, 1, 1, "R11");
      acc(0, 12'h10C, '0, PS, 0, 1, "R11");
      // R7 virtualization ignored in machine mode
      acc(0, 12'h10C, '0, PM, 1, 1, "R7");
      acc(1, 12'h10C, '0, PM, 1, 1, "R7");
      acc(0, 12'h10C, '0, PS, 0, 1, "R7");
      idle();
      // R10 upper halves
      acc(0, 12'h31C, '0, PM, 0, 1, "R10");
      acc(1, 12'h31C, 64'hFFFF_FFFF, PM, 0, 1, "R10");
      acc(1, 12'h31C, '0, PM, 0, 1, "R10");
      acc(0, 12'h30C, '0, PM, 0, 1, "R10");
      acc(0, 12'h60C, '0, PM, 0, 1, "R10");
      acc(1, 12'h31C, 64'h8000_0000, PM, 0, 1, "R10");
      acc(0, 12'h61C, '0, PM, 0, 1, "R10");
      acc(1, 12'h61C, 64'hFFFF_FFFF, PM, 0, 1, "R10");
      acc(0, 12'h61C, '0, PM, 0, 1, "R10");
      acc(0, 12'h60C, '0, PM, 0, 1, "R10");
      // second slot
      acc(1, 12'h30D, '1, PM, 0, 1, "R8");
      acc(1, 12'h60D, '1, PS, 0, 1, "R5");
      acc(1, 12'h10D, '1, PS, 1, 1, "R6");
      acc(0, 12'h10D, '0, PU, 1, 1, "R6");
      idle();

      // Mixed traffic against the model
      for (int t = 0; t < 400; t++) begin
         logic [11:0] a;
         logic [63:0] d;
         int pick;
         pick = int'($urandom_range(0, 5));
         case (pick)
            0: a = 12'h30C;
            1: a = 12'h31C;
            2: a = 12'h60C;
            3: a = 12'h61C;
            4: a = 12'h10C;
            default: a = 12'h300;
         endcase
         a[1:0] = 2'($urandom_range(0, 3));
         d = {$urandom, $urandom};
         acc(bit'($urandom_range(0, 1)), a, d, 2'($urandom_range(0, 3)),
             bit'($urandom_range(0, 1)), ($urandom_range(0, 7) != 0), "R9");
         if (t % 16 == 15) idle();
      end
      idle();

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule